// File: doc/BRIEF.md
# Keypad Interrupt and Mask Controller

This block tracks which of up to sixteen keys are held down and raises an active-low interrupt towards the host when an unmasked key is pressed. A key-matrix scanner, which is outside this block, reports single key events. Each event names a key index and says whether the key went down or came up, and the block keeps a key-down vector from these events. The host uses a small register interface to read that vector, to program a per-key interrupt mask and to set the mode that decides how a pending interrupt is released.

Two mode bits control the release. With mode bit 0 clear, the interrupt drops by itself once no unmasked key remains down. With mode bit 1 set, reading the key-data register acknowledges the interrupt. Whatever the mode, writing the control word with its scan bit set also acknowledges it. The control word also holds a three-bit debounce setting. The block only stores this setting and reads it back; it does no debounce timing.

Top module: `kpad_irq_ctrl`

## Requirements
- R1: A key event with `key_vld` high sets bit `key_idx` of the down vector when `key_down` is 1 and clears it when `key_down` is 0. All other bits keep their value. Reading register select 0 (key data) returns the down vector in bits 15:0.
- R2: A key-down event that leaves at least one unmasked key down, while the interrupt is not pending, makes the interrupt pending. `kp_irq_n` goes low after the next clock edge.
- R3: Pressing a key whose mask bit is 1, with no unmasked key down, does not assert the interrupt.
- R4: With mode bit 0 clear, a pending interrupt is released once no unmasked key is down, even if masked keys are still held.
- R5: With mode bit 0 set, the interrupt stays pending after all keys are released.
- R6: A read of key data releases a pending interrupt when mode bit 1 is set. The same read has no effect on the interrupt when mode bit 1 is clear.
- R7: A write to register select 1 (control) stores the scan bit from bit 14 and the debounce value from bits 13:11. The write releases a pending interrupt only if bit 14 is 1.
- R8: A control read returns the pending flag in bit 15, (scan OR no key down) in bit 14 and the debounce value in bits 13:11. All other bits read as 0.
- R9: A write to register select 2 (configuration) takes mode bits 1:0 from bits 15:14. A read of it returns mode bit 0 in bit 14 and 0 in every other bit.
- R10: Register select 3 is the interrupt mask. Bit k masks key k. Its value reads back exactly as written.
- R11: After reset the down vector is 0, scan is 1, debounce is 0, the mask is 0x0000, the mode is 3, no interrupt is pending and `kp_irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | Key event strobe, one event per cycle |
| key_idx | input | 4 | Index of the key for the event |
| key_down | input | 1 | 1 = key pressed, 0 = key released |
| reg_sel | input | 2 | 0 key data, 1 control, 2 configuration, 3 mask |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, combinational |
| kp_irq_n | output | 1 | Keypad interrupt, active low |

## Verification
The assertions check the cycle-level rules on every clock edge. These are the bit update for a key event, the pending flag setting on an unmasked press, the flag staying clear when no press arrives, the automatic drop in mode 0, holding in mode 1, the acknowledge on a data read and the capture of the mode bits. Only the bench scenarios can show the register word layouts, the full sweep over every key index against single-bit masks, and the combined cases. Those combined cases are masked keys held while an unmasked key is released, and a scan-clear write compared with a plain debounce write.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  localparam int KP_DW = 16;

  typedef enum logic [1:0] {
    KP_SEL_DATA = 2'd0,
    KP_SEL_STAT = 2'd1,
    KP_SEL_CFG  = 2'd2,
    KP_SEL_MASK = 2'd3
  } kp_sel_e;

  // control word as seen by the host
  function automatic logic [KP_DW-1:0] kp_stat_word(input logic pend, input logic scan,
                                                    input logic none_down,
                                                    input logic [2:0] deb);
    logic [KP_DW-1:0] w;
    w        = '0;
    w[15]    = pend;
    w[14]    = scan | none_down;
    w[13:11] = deb;
    return w;
  endfunction

  // configuration word: only mode bit 0 is visible
  function automatic logic [KP_DW-1:0] kp_cfg_word(input logic [1:0] mode);
    logic [KP_DW-1:0] w;
    w     = '0;
    w[14] = mode[0];
    return w;
  endfunction

endpackage

// File: rtl/kpad_keyvec.sv
module kpad_keyvec #(
  parameter int KEYS = 16,
  localparam int IDXW = $clog2(KEYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_vld,
  input  logic [IDXW-1:0] key_idx,
  input  logic            key_down,
  output logic [KEYS-1:0] down_q,
  output logic [KEYS-1:0] down_nxt
);

  for (genvar g = 0; g < KEYS; g++) begin : g_bit
    logic hit;
    assign hit         = key_vld && (key_idx == IDXW'(g));
    assign down_nxt[g] = hit ? key_down : down_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) down_q[g] <= 1'b0;
      else        down_q[g] <= down_nxt[g];
    end
  end

  AST_KEY_BIT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |=> down_q[$past(key_idx)] == $past(key_down)); // R1

  AST_KEY_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_vld |=> $stable(down_q)); // R1

endmodule

// File: rtl/kpad_irq_fsm.sv
module kpad_irq_fsm #(
  parameter int KEYS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] down_nxt,
  input  logic [KEYS-1:0] mask_q,
  input  logic [1:0]      mode_q,
  input  logic            press_evt,
  input  logic            data_rd,
  input  logic            scan_ack,
  output logic            pend_q
);

  logic unmasked_any, set_evt, rd_ack, auto_rel, clr_evt;

  assign unmasked_any = |(down_nxt & ~mask_q);
  assign set_evt      = press_evt && unmasked_any && !pend_q;
  assign rd_ack       = data_rd && mode_q[1];
  assign auto_rel     = !mode_q[0] && !unmasked_any;
  assign clr_evt      = rd_ack || scan_ack || auto_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (press_evt && unmasked_any) |=> pend_q); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !press_evt) |=> !pend_q); // R3

  AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[0] && !unmasked_any) |=> !pend_q); // R4

  AST_HOLD_MODE1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mode_q[0] && !rd_ack && !scan_ack) |=> pend_q); // R5

  AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !press_evt) |=> !pend_q); // R6

  AST_SCAN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ack && !press_evt) |=> !pend_q); // R7

endmodule

// File: rtl/kpad_regs.sv
module kpad_regs
  import kpad_pkg::*;
#(
  parameter int KEYS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kp_sel_e          sel,
  input  logic             wr,
  input  logic [KP_DW-1:0] wdata,
  input  logic [KEYS-1:0]  down_q,
  input  logic             pend_q,
  output logic [KEYS-1:0]  mask_q,
  output logic [1:0]       mode_q,
  output logic             scan_ack,
  output logic [KP_DW-1:0] rdata
);

  logic       scan_q;
  logic [2:0] deb_q;
  logic       wr_stat, wr_cfg, wr_mask;

  assign wr_stat  = wr && (sel == KP_SEL_STAT);
  assign wr_cfg   = wr && (sel == KP_SEL_CFG);
  assign wr_mask  = wr && (sel == KP_SEL_MASK);
  assign scan_ack = wr_stat && wdata[14];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b1;
      deb_q  <= 3'd0;
      mode_q <= 2'd3;
      mask_q <= '0;
    end else begin
      if (wr_stat) begin
        scan_q <= wdata[14];
        deb_q  <= wdata[13:11];
      end
      if (wr_cfg)  mode_q <= wdata[15:14];
      if (wr_mask) mask_q <= wdata[KEYS-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      KP_SEL_DATA: rdata = KP_DW'(down_q);
      KP_SEL_STAT: rdata = kp_stat_word(pend_q, scan_q, ~|down_q, deb_q);
      KP_SEL_CFG:  rdata = kp_cfg_word(mode_q);
      default:     rdata = KP_DW'(mask_q);
    endcase
  end

  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> mode_q == $past(wdata[15:14])); // R9

  AST_MASK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(wdata[KEYS-1:0])); // R10

endmodule

// File: rtl/kpad_irq_ctrl.sv
module kpad_irq_ctrl
  import kpad_pkg::*;
#(
  parameter int KEYS = 16,
  localparam int IDXW = $clog2(KEYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_vld,
  input  logic [IDXW-1:0] key_idx,
  input  logic            key_down,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  output logic            kp_irq_n
);

  kp_sel_e         sel;
  logic [KEYS-1:0] down_q, down_nxt, mask_q;
  logic [1:0]      mode_q;
  logic            pend_q, scan_ack, press_evt, data_rd;

  assign sel       = kp_sel_e'(reg_sel);
  assign press_evt = key_vld && key_down;
  assign data_rd   = reg_rd && (sel == KP_SEL_DATA);
  assign kp_irq_n  = ~pend_q;

  kpad_keyvec #(.KEYS(KEYS)) u_keyvec (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_idx(key_idx),
    .key_down(key_down), .down_q(down_q), .down_nxt(down_nxt)
  );

  kpad_irq_fsm #(.KEYS(KEYS)) u_irq (
    .clk(clk), .rst_n(rst_n), .down_nxt(down_nxt), .mask_q(mask_q),
    .mode_q(mode_q), .press_evt(press_evt), .data_rd(data_rd),
    .scan_ack(scan_ack), .pend_q(pend_q)
  );

  kpad_regs #(.KEYS(KEYS)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(reg_wr), .wdata(reg_wdata),
    .down_q(down_q), .pend_q(pend_q), .mask_q(mask_q), .mode_q(mode_q),
    .scan_ack(scan_ack), .rdata(reg_rdata)
  );

  AST_RESET_LINE_HIGH: assert property (@(posedge clk)
    !rst_n |=> kp_irq_n); // R11

endmodule

// File: tb/tb_kpad_irq_ctrl.sv
module tb_kpad_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_vld = 1'b0;
  logic [3:0]  key_idx = '0;
  logic        key_down = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        kp_irq_n;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  kpad_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_idx(key_idx),
    .key_down(key_down), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kp_irq_n(kp_irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic key(input int k, input logic dn);
    key_vld = 1'b1; key_idx = 4'(k); key_down = dn;
    @(negedge clk);
    key_vld = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, expv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq", 16'(kp_irq_n), 16'h1);
    rd(2'd0, v); chk("R11 data", v, 16'h0000);
    rd(2'd1, v); chk("R11 stat", v, 16'h4000);
    rd(2'd2, v); chk("R11 cfg", v, 16'h4000);
    rd(2'd3, v); chk("R11 mask", v, 16'h0000);

    // R1 sweep: set then clear each key
    expv = '0;
    for (int k = 0; k < 16; k++) begin
      key(k, 1'b1); expv[k] = 1'b1;
      rd(2'd0, v); chk("R1 set", v, expv);
    end
    for (int k = 0; k < 16; k++) begin
      key(k, 1'b0); expv[k] = 1'b0;
      rd(2'd0, v); chk("R1 clr", v, expv);
    end

    // mode 0: auto release
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R9 cfg mode0", v, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      key(k, 1'b1); chk("R2 press", 16'(kp_irq_n), 16'h0);
      key(k, 1'b0); chk("R4 release", 16'(kp_irq_n), 16'h1);
    end

    // R3 masked keys, one at a time
    for (int k = 0; k < 16; k++) begin
      wr(2'd3, 16'(1) << k);
      key(k, 1'b1); chk("R3 masked", 16'(kp_irq_n), 16'h1);
      key(k, 1'b0);
    end

    // R4 masked key held while unmasked one released
    wr(2'd3, 16'h0008);
    key(3, 1'b1);
    key(5, 1'b1); chk("R2 unmasked with masked", 16'(kp_irq_n), 16'h0);
    key(5, 1'b0); chk("R4 masked held", 16'(kp_irq_n), 16'h1);
    key(3, 1'b0);

    // R10 mask read back
    wr(2'd3, 16'hA5C3);
    rd(2'd3, v); chk("R10 mask", v, 16'hA5C3);
    wr(2'd3, 16'h0000);

    // mode 1: hold, data read no effect, scan ack
    wr(2'd2, 16'h4000);
    wr(2'd1, 16'h2800);
    rd(2'd1, v); chk("R8 stat idle", v, 16'h6800);
    key(2, 1'b1);
    key(2, 1'b0); chk("R5 hold", 16'(kp_irq_n), 16'h0);
    rd(2'd0, v); chk("R6 no ack mode1=0", 16'(kp_irq_n), 16'h0);
    wr(2'd1, 16'h0000); chk("R7 scan0 no ack", 16'(kp_irq_n), 16'h0);
    wr(2'd1, 16'h4000); chk("R7 scan1 ack", 16'(kp_irq_n), 16'h1);
    wr(2'd1, 16'h2800);
    key(1, 1'b1);
    rd(2'd1, v); chk("R8 stat pending", v, 16'hA800);
    wr(2'd1, 16'h7000);
    rd(2'd1, v); chk("R7 stat stored", v, 16'h7000);
    key(1, 1'b0);

    // mode 3: data read acknowledges
    wr(2'd2, 16'hC000);
    key(4, 1'b1); chk("R2 press mode3", 16'(kp_irq_n), 16'h0);
    rd(2'd0, v); chk("R1 data", v, 16'h0010);
    chk("R6 read ack", 16'(kp_irq_n), 16'h1);
    rd(2'd2, v); chk("R9 cfg mode3", v, 16'h4000);
    wr(2'd2, 16'h8000);
    rd(2'd2, v); chk("R9 cfg mode2", v, 16'h0000);
    key(4, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule